// File: doc/BRIEF.md
# Four-Voice Wavetable Oscillator Mixer

This block produces one stereo 8-bit sample for each sample-rate strobe by running four numerically controlled oscillators over wavetables. Each voice keeps a 24-bit phase and a 24-bit step, both unsigned fixed point with 9 integer bits and 15 fractional bits. On every accepted strobe, each voice adds its step to its phase and keeps the wrapped result. The upper 9 bits of the new phase select one of 512 entries in a wavetable.

The tables live in two external 1024-byte sample memories. Voices 0 and 1 read memory A and voices 2 and 3 read memory B, always from the upper half of the memory. The memories are synchronous, so read data returns one clock after the address. The four samples are averaged and the same value is driven on both the left and the right output.

The voices are processed one per clock, and a one-cycle valid pulse marks each new output. A byte-wide register port gives the host access to every phase and step. Each value is presented as a big-endian 32-bit word whose top byte is always zero. The engine advances only while the mode input holds the run code.

Top module: `wavetable_mix4`

## Requirements
- R1: After reset `out_valid` is 0, both outputs are 0x00, and every register byte reads 0x00.
- R2: Register map:
  - Voice v has its phase word at byte address 0x10+8v and its step word at 0x14+8v.
  - Byte k of a word (k=0..3) sits at word address + k, in big-endian order: k=1 holds bits 23:16, k=2 holds bits 15:8 and k=3 holds bits 7:0.
  - Byte k=0 always reads 0x00, and writes to it are ignored.
  - Addresses outside 0x10..0x2F read 0x00, and writes to them are ignored.
- R3: On each accepted strobe, every voice's phase becomes phase+step, and a host read afterwards returns the advanced phase.
- R4: The table index is bits 23:15 of the advanced phase. Voices 0 and 1 read memory A and voices 2 and 3 read memory B, each at address 0x200+index. At most one memory is read per clock.
- R5: Each output sample equals (s0+s1+s2+s3)>>2 of the four unsigned samples, and `left_out` equals `right_out`.
- R6: Timing of `out_valid`:
  - Take the rising edge that samples an accepted strobe as edge 0. `out_valid` is then high for exactly one cycle, following rising edge 5.
  - The outputs hold their value between pulses.
- R7: While `mode` is not 2, a strobe is ignored. No memory is read, the phases stay unchanged, and no valid pulse appears.
- R8: A strobe that arrives while a sample is still being computed is ignored. Only one output and one phase advance result.
- R9: Phase arithmetic wraps modulo 2^24. For example, 0xFFFFF0 plus a step of 0x000020 gives 0x000010, and a step of 0xFFFFFF steps the phase back by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Engine mode; value 2 runs the oscillators |
| tick | input | 1 | Sample-rate strobe, one cycle |
| reg_we | input | 1 | Register byte write enable |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte (combinational) |
| mema_rd | output | 1 | Read strobe to sample memory A |
| mema_addr | output | 10 | Read address to sample memory A |
| mema_data | input | 8 | Read data from memory A, one cycle after the address |
| memb_rd | output | 1 | Read strobe to sample memory B |
| memb_addr | output | 10 | Read address to sample memory B |
| memb_data | input | 8 | Read data from memory B, one cycle after the address |
| left_out | output | 8 | Mixed sample, left |
| right_out | output | 8 | Mixed sample, right |
| out_valid | output | 1 | One-cycle pulse per new stereo sample |

## Verification
A wrong phase update shows up in two places. It skews the very next output sample, five cycles after the strobe, because the index is taken from the advanced phase. It also shows up in the phase read back after that strobe. Because the memories hold distinct values in both halves and in both memories, a wrong memory choice, a wrong half or a wrong index bit changes the averaged sample on that strobe. A stuck sequencer or a lost pipeline stage shows up as a missing, late or doubled valid pulse. A leaked update in an idle mode shows up as a memory read or a changed phase.

// File: rtl/wtmix_pkg.sv
package wtmix_pkg;
  localparam int PHASE_W    = 24;
  localparam int FRAC_W     = 15;
  localparam int SAMP_W     = 8;
  localparam int NUM_VOICES = 4;
  localparam int REG_AW     = 6;
  localparam int REG_BASE   = 16;
  localparam int RUN_MODE   = 2;
endpackage

// File: rtl/wtmix_regs.sv
module wtmix_regs
  import wtmix_pkg::*;
#(
  parameter int NV   = NUM_VOICES,
  parameter int PW   = PHASE_W,
  parameter int AW   = REG_AW,
  parameter int BASE = REG_BASE,
  localparam int VW  = $clog2(NV),
  localparam int SPAN = 8 * NV
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          eng_we,
  input  logic [VW-1:0] eng_voice,
  input  logic [PW-1:0] eng_phase_new,
  output logic [PW-1:0] cur_phase,
  output logic [PW-1:0] cur_incr
);

  logic [PW-1:0] phase_q [NV];
  logic [PW-1:0] phase_d [NV];
  logic [PW-1:0] incr_q  [NV];
  logic [PW-1:0] incr_d  [NV];

  logic [AW-1:0] rel;
  logic          in_win;
  logic [VW-1:0] h_voice;
  logic          h_incr;
  logic [1:0]    h_byte;
  logic [4:0]    sh;
  logic [31:0]   mask;
  logic [31:0]   ins;
  logic [31:0]   rd_word;

  // host address decode: 32-bit big-endian words, voice stride 8
  always_comb begin
    rel     = host_addr - AW'(BASE);
    in_win  = (host_addr >= AW'(BASE)) &&
              ({1'b0, host_addr} < (AW+1)'(BASE + SPAN));
    h_voice = rel[3 +: VW];
    h_incr  = rel[2];
    h_byte  = rel[1:0];
    sh      = {~h_byte, 3'b000};
    mask    = 32'h0000_00FF << sh;
    ins     = {24'h0, host_wdata} << sh;
    rd_word = h_incr ? 32'(incr_q[h_voice]) : 32'(phase_q[h_voice]);
    host_rdata = in_win ? rd_word[sh +: 8] : 8'h00;
  end

  // next-state: host byte write takes precedence over engine update
  always_comb begin
    for (int v = 0; v < NV; v++) begin
      phase_d[v] = phase_q[v];
      incr_d[v]  = incr_q[v];
      if (eng_we && (eng_voice == VW'(v)))
        phase_d[v] = eng_phase_new;
      if (host_we && in_win && (h_voice == VW'(v))) begin
        if (h_incr)
          incr_d[v]  = PW'((32'(incr_q[v]) & ~mask) | ins);
        else
          phase_d[v] = PW'((32'(phase_q[v]) & ~mask) | ins);
      end
    end
  end

  generate
    for (genvar g = 0; g < NV; g++) begin : g_voice
      logic ph_en;
      logic in_en;
      assign ph_en = host_we || (eng_we && (eng_voice == VW'(g)));
      assign in_en = host_we;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          phase_q[g] <= '0;
          incr_q[g]  <= '0;
        end else begin
          if (ph_en) phase_q[g] <= phase_d[g];
          if (in_en) incr_q[g]  <= incr_d[g];
        end
      end

      // R7
      phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_we && !host_we) |=> $stable(phase_q[g]));
      // R2
      step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_we |=> $stable(incr_q[g]));
    end
  endgenerate

  assign cur_phase = phase_q[eng_voice];
  assign cur_incr  = incr_q[eng_voice];

endmodule

// File: rtl/wtmix_seq.sv
module wtmix_seq
  import wtmix_pkg::*;
#(
  parameter int NV  = NUM_VOICES,
  localparam int VW = $clog2(NV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run_en,
  output logic          issue,
  output logic [VW-1:0] issue_voice,
  output logic          rsp_valid,
  output logic [VW-1:0] rsp_voice
);

  logic          busy_q, busy_d;
  logic [VW-1:0] vidx_q, vidx_d;
  logic          rsp_valid_q;
  logic [VW-1:0] rsp_voice_q;

  always_comb begin
    busy_d = busy_q;
    vidx_d = vidx_q;
    if (!busy_q) begin
      if (tick && run_en) begin
        busy_d = 1'b1;
        vidx_d = '0;
      end
    end else begin
      vidx_d = vidx_q + 1'b1;
      if (vidx_q == VW'(NV - 1))
        busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      vidx_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_voice_q <= '0;
    end else begin
      busy_q      <= busy_d;
      vidx_q      <= vidx_d;
      rsp_valid_q <= busy_q;
      rsp_voice_q <= vidx_q;
    end
  end

  assign issue       = busy_q;
  assign issue_voice = vidx_q;
  assign rsp_valid   = rsp_valid_q;
  assign rsp_voice   = rsp_voice_q;

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !(tick && run_en)) |=> !busy_q);
  // R6
  start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (vidx_q == '0));
  // R8
  busy_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (vidx_q != VW'(NV - 1))) |=> busy_q);

endmodule

// File: rtl/wtmix_mix.sv
module wtmix_mix
  import wtmix_pkg::*;
#(
  parameter int NV  = NUM_VOICES,
  parameter int SW  = SAMP_W,
  localparam int VW = $clog2(NV),
  localparam int SUM_W = SW + VW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rsp_valid,
  input  logic [VW-1:0] rsp_voice,
  input  logic [SW-1:0] rsp_data,
  output logic [SW-1:0] mix_out,
  output logic          mix_valid
);

  logic [SUM_W-1:0] acc_q, acc_d;
  logic [SW-1:0]    out_q, out_d;
  logic             vld_q, vld_d;
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum   = ((rsp_voice == '0) ? '0 : acc_q) + SUM_W'(rsp_data);
    acc_d = acc_q;
    out_d = out_q;
    vld_d = 1'b0;
    if (rsp_valid) begin
      acc_d = sum;
      if (rsp_voice == VW'(NV - 1)) begin
        out_d = SW'(sum >> VW);
        vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (rsp_valid) acc_q <= acc_d;
      if (vld_d)     out_q <= out_d;
      vld_q <= vld_d;
    end
  end

  assign mix_out   = out_q;
  assign mix_valid = vld_q;

  // R6
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mix_valid |=> !mix_valid);
  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mix_valid |-> $stable(mix_out));
  // R5
  after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mix_valid |-> $past(rsp_valid));

endmodule

// File: rtl/wavetable_mix4.sv
module wavetable_mix4
  import wtmix_pkg::*;
#(
  parameter int NV   = NUM_VOICES,
  parameter int PW   = PHASE_W,
  parameter int FW   = FRAC_W,
  parameter int SW   = SAMP_W,
  parameter int AW   = REG_AW,
  parameter int BASE = REG_BASE,
  parameter int RUN  = RUN_MODE,
  localparam int VW  = $clog2(NV),
  localparam int IDX_W = PW - FW,
  localparam int MEM_AW = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              tick,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              mema_rd,
  output logic [MEM_AW-1:0] mema_addr,
  input  logic [SW-1:0]     mema_data,
  output logic              memb_rd,
  output logic [MEM_AW-1:0] memb_addr,
  input  logic [SW-1:0]     memb_data,
  output logic [SW-1:0]     left_out,
  output logic [SW-1:0]     right_out,
  output logic              out_valid
);

  logic          issue;
  logic [VW-1:0] issue_voice;
  logic          rsp_valid;
  logic [VW-1:0] rsp_voice;
  logic [PW-1:0] cur_phase, cur_incr, new_phase;
  logic [IDX_W-1:0] tbl_idx;
  logic [SW-1:0] rsp_data;
  logic [SW-1:0] mix_out;
  logic          run_en;

  assign run_en = (mode == 2'(RUN));

  wtmix_seq #(.NV(NV)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_en),
    .issue(issue), .issue_voice(issue_voice),
    .rsp_valid(rsp_valid), .rsp_voice(rsp_voice)
  );

  wtmix_regs #(.NV(NV), .PW(PW), .AW(AW), .BASE(BASE)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_we(reg_we), .host_addr(reg_addr), .host_wdata(reg_wdata),
    .host_rdata(reg_rdata),
    .eng_we(issue), .eng_voice(issue_voice), .eng_phase_new(new_phase),
    .cur_phase(cur_phase), .cur_incr(cur_incr)
  );

  // one shared adder; wraps modulo 2^PW
  assign new_phase = cur_phase + cur_incr;
  assign tbl_idx   = new_phase[PW-1 -: IDX_W];

  // lower voice pair -> memory A, upper pair -> memory B, upper half of each
  assign mema_rd   = issue && !issue_voice[VW-1];
  assign memb_rd   = issue &&  issue_voice[VW-1];
  assign mema_addr = {1'b1, tbl_idx};
  assign memb_addr = {1'b1, tbl_idx};
  assign rsp_data  = rsp_voice[VW-1] ? memb_data : mema_data;

  wtmix_mix #(.NV(NV), .SW(SW)) u_mix (
    .clk(clk), .rst_n(rst_n),
    .rsp_valid(rsp_valid), .rsp_voice(rsp_voice), .rsp_data(rsp_data),
    .mix_out(mix_out), .mix_valid(out_valid)
  );

  assign left_out  = mix_out;
  assign right_out = mix_out;

  // R4
  one_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mema_rd && memb_rd));
  // R4
  upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mema_rd |-> mema_addr[MEM_AW-1]) and (memb_rd |-> memb_addr[MEM_AW-1]));
  // R7
  idle_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !issue) |=> !(mema_rd || memb_rd) || $past(issue));

endmodule

// File: tb/sim_wavetable_mix4.sv
module sim_wavetable_mix4;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       tick;
  logic       reg_we;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       mema_rd, memb_rd;
  logic [9:0] mema_addr, memb_addr;
  logic [7:0] mema_data, memb_data;
  logic [7:0] left_out, right_out;
  logic       out_valid;

  int checks = 0;
  int fails  = 0;
  int rdcount = 0;
  logic [23:0] ph  [4];
  logic [23:0] inc [4];

  always #5 clk = ~clk;

  wavetable_mix4 u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .mema_rd(mema_rd), .mema_addr(mema_addr), .mema_data(mema_data),
    .memb_rd(memb_rd), .memb_addr(memb_addr), .memb_data(memb_data),
    .left_out(left_out), .right_out(right_out), .out_valid(out_valid)
  );

  function automatic logic [7:0] fa(int a);
    return 8'((a * 37 + 11) ^ (a >> 5));
  endfunction
  function automatic logic [7:0] fb(int a);
    return 8'((a * 101 + 200) ^ (a >> 3));
  endfunction

  // synchronous sample memories
  always @(posedge clk) begin
    if (mema_rd) mema_data <= fa(int'(mema_addr));
    if (memb_rd) memb_data <= fb(int'(memb_addr));
    if (mema_rd || memb_rd) rdcount <= rdcount + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr_word(input logic [5:0] a, input logic [23:0] v);
    wr(a + 6'd1, v[23:16]);
    wr(a + 6'd2, v[15:8]);
    wr(a + 6'd3, v[7:0]);
  endtask

  task automatic rd_word(input logic [5:0] a, output logic [23:0] v);
    logic [7:0] b;
    rd(a + 6'd1, b); v[23:16] = b;
    rd(a + 6'd2, b); v[15:8]  = b;
    rd(a + 6'd3, b); v[7:0]   = b;
  endtask

  task automatic load_voice(input int v, input logic [23:0] p, input logic [23:0] s);
    wr_word(6'(16 + 8 * v), p);
    wr_word(6'(20 + 8 * v), s);
    ph[v] = p; inc[v] = s;
  endtask

  function automatic logic [7:0] model_tick();
    int sum = 0;
    for (int v = 0; v < 4; v++) begin
      ph[v] = ph[v] + inc[v];
      if (v < 2) sum += int'(fa(512 + int'(ph[v][23:15])));
      else       sum += int'(fb(512 + int'(ph[v][23:15])));
    end
    return 8'(sum >> 2);
  endfunction

  // strobe and wait for the valid pulse; checks R5, R6
  task automatic tick_check(input string tag);
    int lat;
    logic [7:0] exp;
    exp = model_tick();
    @(negedge clk); tick = 1'b1;
    @(posedge clk);
    @(negedge clk); tick = 1'b0;
    lat = 0;
    while (lat < 12) begin
      @(posedge clk); @(negedge clk);
      lat++;
      if (out_valid) break;
    end
    check(lat == 5, {"R6 latency ", tag}, lat, 5);
    check(left_out == exp, {"R5 left ", tag}, left_out, exp);
    check(right_out == exp, {"R5 right ", tag}, right_out, exp);
    @(negedge clk);
    check(!out_valid, {"R6 pulse width ", tag}, out_valid, 0);
  endtask

  task automatic check_phases(input string req);
    logic [23:0] got;
    for (int v = 0; v < 4; v++) begin
      rd_word(6'(16 + 8 * v), got);
      check(got == ph[v], req, got, ph[v]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [23:0] w;
    logic [31:0] lcg;
    int n0, vcount;
    rst_n = 1'b0; mode = 2'd0; tick = 1'b0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(!out_valid, "R1 valid", out_valid, 0);
    check(left_out == 8'h00 && right_out == 8'h00, "R1 outputs", left_out, 0);
    for (int a = 0; a < 64; a++) begin
      rd(6'(a), b);
      check(b == 8'h00, "R1 register read", b, 0);
    end

    // R2 byte map
    for (int v = 0; v < 4; v++)
      load_voice(v, 24'h123456 + 24'(v * 24'h010101), 24'hA0B0C0 - 24'(v * 24'h020202));
    for (int v = 0; v < 4; v++) begin
      rd(6'(16 + 8 * v + 1), b);
      check(b == ph[v][23:16], "R2 phase byte1", b, ph[v][23:16]);
      rd(6'(16 + 8 * v + 3), b);
      check(b == ph[v][7:0], "R2 phase byte3", b, ph[v][7:0]);
      rd(6'(20 + 8 * v + 2), b);
      check(b == inc[v][15:8], "R2 step byte2", b, inc[v][15:8]);
      wr(6'(16 + 8 * v), 8'hAA);
      rd(6'(16 + 8 * v), b);
      check(b == 8'h00, "R2 top byte ignored", b, 0);
    end
    check_phases("R2 top byte write leaves phase");
    wr(6'h0F, 8'h55); wr(6'h30, 8'h66);
    rd(6'h0F, b); check(b == 8'h00, "R2 below window", b, 0);
    rd(6'h30, b); check(b == 8'h00, "R2 above window", b, 0);
    check_phases("R2 outside writes ignored");

    // main sweep, several step patterns; R3 R4 R5 R6 R9
    mode = 2'd2;
    lcg = 32'h1357_9BDF;
    for (int cfg = 0; cfg < 5; cfg++) begin
      for (int v = 0; v < 4; v++) begin
        case (cfg)
          0: load_voice(v, 24'h0, 24'(24'h008000 * (v + 1)));
          1: load_voice(v, 24'(v * 24'h3F0000), (v == 1) ? 24'hFFFFFF : 24'(24'h000123 + v * 24'h1ABCDE));
          2: load_voice(v, 24'hFF8000, 24'h7FFFFF + 24'(v));
          default: begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            load_voice(v, lcg[31:8], {lcg[15:0], lcg[31:24]});
          end
        endcase
      end
      for (int t = 0; t < 20; t++) begin
        tick_check("sweep");
        if (t % 4 == 3) check_phases("R3 advanced phase readback");
      end
    end

    // R9 explicit wrap
    load_voice(0, 24'hFFFFF0, 24'h000020);
    tick_check("wrap");
    rd_word(6'h10, w);
    check(w == 24'h000010, "R9 wrap result", w, 24'h000010);
    load_voice(1, 24'h000005, 24'hFFFFFF);
    tick_check("back step");
    rd_word(6'h18, w);
    check(w == 24'h000004, "R9 step back by one", w, 24'h000004);
    check_phases("R4 R3 after wrap");

    // R7 idle modes
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      mode = 2'(m);
      n0 = rdcount; vcount = 0;
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      repeat (10) begin
        @(negedge clk);
        if (out_valid) vcount++;
      end
      check(vcount == 0, "R7 no valid when idle", vcount, 0);
      check(rdcount == n0, "R7 no memory read when idle", rdcount - n0, 0);
      check_phases("R7 phases unchanged when idle");
    end

    // R8 strobe during busy ignored
    mode = 2'd2;
    begin
      logic [7:0] exp;
      exp = model_tick();
      n0 = rdcount; vcount = 0;
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      repeat (14) begin
        @(negedge clk);
        if (out_valid) begin
          vcount++;
          check(left_out == exp, "R8 single result value", left_out, exp);
        end
      end
      check(vcount == 1, "R8 one pulse", vcount, 1);
      check(rdcount - n0 == 4, "R8 four reads", rdcount - n0, 4);
      check_phases("R8 single phase advance");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule